// File: doc/BRIEF.md
# Background, Video and Icon Overlay Mixer

This block builds an output video stream from three contributions. The first is a black background whose size software sets. The second is a processed video layer. The third is a small icon that is blended on top of both at half strength. Every stream moves two pixels per clock, each pixel being three 10-bit colour planes. Streams use a valid/ready handshake, mark the first beat of a frame with a start-of-frame flag, and the output also marks the last beat of each line.

The background raster is produced for every frame whether or not any video arrives. The video layer joins a frame only when two things are true at that frame's first output beat: the input-stable flag is high, and the start-of-frame beat of the video stream is waiting. A frame never waits for the video layer. A beat the video source fails to supply is filled from the background, and user-packet beats are accepted and thrown away. The icon's enable and its offset from the top-right corner are sampled at each output start of frame, the same as the raster size.

Top module: `video_overlay_mixer`

## Requirements
- R1: While reset is applied, and until the internal reset synchroniser has released, out_valid is 0. The first output beat afterwards carries out_sof = 1.
- R2: A frame is (cfg_width/2) beats per line by cfg_height lines, in raster order. out_sof marks beat (0,0) and out_eol marks the last beat of each line. cfg_width and cfg_height are sampled on the start-of-frame beat and hold for the rest of the frame.
- R3: Where no layer contributes, every plane is 0. Once out_valid has risen it stays high, so the background never stops. Pixel h of a beat sits at bits [30h +: 30] and plane p of that pixel at bits [10p +: 10].
- R4: Video pixels appear in a frame only if vid_stable is 1 and a video start-of-frame beat is waiting when the output start-of-frame beat is produced. Outside such frames a waiting video start-of-frame beat is held, and video beats that are not start-of-frame are accepted and discarded.
- R5: In a frame that has the video layer, one video beat is used per output beat. An output beat for which no video beat is valid shows the background, and the frame goes on without delay.
- R6: The icon is ICON_W by ICON_H pixels. Its left column is at pair (cfg_width/2 − ICON_W/2 − cfg_icon_dx) and its top row at cfg_icon_dy, so zero offsets put it in the top-right corner. Icon beats are consumed only inside that window. Each plane there is (under + icon + 1) >> 1, where "under" is the background or video value.
- R7: cfg_icon_en, cfg_icon_dx and cfg_icon_dy are sampled on the output start-of-frame beat. A change made during a frame has no effect until the next frame.
- R8: A beat with the user flag set is accepted at any time and never reaches the output.
- R9: While out_valid is 1 and out_ready is 0, the output beat holds and no input beat is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 12 | Frame width in pixels (even) |
| cfg_height | input | 12 | Frame height in lines |
| cfg_icon_en | input | 1 | Icon shown when 1 |
| cfg_icon_dx | input | 11 | Icon offset from right edge, in pixel pairs |
| cfg_icon_dy | input | 12 | Icon offset from top edge, in lines |
| vid_stable | input | 1 | Video input is active and stable |
| l1_valid | input | 1 | Video beat valid |
| l1_ready | output | 1 | Video beat accepted |
| l1_data | input | 60 | Video beat, two pixels |
| l1_sof | input | 1 | Video start of frame |
| l1_user | input | 1 | Video beat belongs to a user packet |
| ic_valid | input | 1 | Icon beat valid |
| ic_ready | output | 1 | Icon beat accepted |
| ic_data | input | 60 | Icon beat, two pixels |
| ic_sof | input | 1 | Icon start of frame |
| ic_user | input | 1 | Icon beat belongs to a user packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken |
| out_data | output | 60 | Output beat, two pixels |
| out_sof | output | 1 | Output start of frame |
| out_eol | output | 1 | Output end of line |

## Verification
The collision of interest is the icon blend landing on a beat the video layer has just stopped supplying. The icon must then average with black, not with stale video data. To provoke it, the bench cuts each video frame short partway through the icon window, which also puts user-packet beats on the video input during the gap. Every output beat is compared with a value the bench computes from its own position model. That model decides, beat by beat, whether video, icon, both or neither apply, so beats inside the cut window that blend with the background are told apart from those that blend with video.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int PPC    = 2;
  localparam int PLANES = 3;
  localparam int BPC    = 10;
  localparam int DW     = PPC * PLANES * BPC;

  typedef logic [BPC-1:0] plane_t;

  // rounded mean of two planes
  function automatic plane_t half_mix(input plane_t a, input plane_t b);
    logic [BPC:0] s;
    s = {1'b0, a} + {1'b0, b} + {{BPC{1'b0}}, 1'b1};
    return s[BPC:1];
  endfunction
endpackage

// File: rtl/mix_scan.sv
module mix_scan #(
  parameter int XW = 11,
  parameter int YW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [XW-1:0] w_live,
  input  logic [YW-1:0] h_live,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          sof,
  output logic          eol,
  output logic [XW-1:0] w_eff
);
  logic [XW-1:0] x_q, x_d, w_q, w_d, last_x;
  logic [YW-1:0] y_q, y_d, h_q, h_d, h_eff, last_y;

  always_comb begin
    sof    = (x_q == '0) && (y_q == '0);
    w_eff  = sof ? w_live : w_q;
    h_eff  = sof ? h_live : h_q;
    last_x = (w_eff == '0) ? '0 : w_eff - 1'b1;
    last_y = (h_eff == '0) ? '0 : h_eff - 1'b1;
    eol    = (x_q == last_x);
    x_d    = x_q;
    y_d    = y_q;
    w_d    = w_q;
    h_d    = h_q;
    if (adv) begin
      if (sof) begin
        w_d = w_live;
        h_d = h_live;
      end
      if (eol) begin
        x_d = '0;
        y_d = (y_q >= last_y) ? '0 : y_q + 1'b1;
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      w_q <= '0;
      h_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
      w_q <= w_d;
      h_q <= h_d;
    end
  end

  assign x = x_q;
  assign y = y_q;

  // R2
  scan_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && eol |=> x_q == '0);
endmodule

// File: rtl/mix_layer_port.sv
module mix_layer_port #(
  parameter int DW = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          adv,
  input  logic          frame_start,
  input  logic          en,
  input  logic          want,
  input  logic          s_valid,
  input  logic          s_sof,
  input  logic          s_user,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic          hit,
  output logic [DW-1:0] pix
);
  logic locked_q, locked_d, lock_now, active;

  always_comb begin
    lock_now = en && s_valid && s_sof && !s_user;
    active   = frame_start ? lock_now : locked_q;
    // unlocked: hold a waiting frame start, drain everything else
    s_ready  = run && (s_user || (active ? (adv && want) : !s_sof));
    hit      = active && adv && want && s_valid && !s_user;
    locked_d = (adv && frame_start) ? lock_now : locked_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b0;
    else        locked_q <= locked_d;
  end

  assign pix = s_data;

  // R4
  port_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && frame_start && !lock_now |=> !hit || frame_start);
endmodule

// File: rtl/mix_blend.sv
module mix_blend
  import mix_pkg::*;
(
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] ovl,
  input  logic          ovl_en,
  output logic [DW-1:0] px
);
  for (genvar g = 0; g < PPC * PLANES; g++) begin : g_plane
    plane_t mixed;
    assign mixed = half_mix(base[g*BPC +: BPC], ovl[g*BPC +: BPC]);
    assign px[g*BPC +: BPC] = ovl_en ? mixed : base[g*BPC +: BPC];
  end
endmodule

// File: rtl/video_overlay_mixer.sv
module video_overlay_mixer
  import mix_pkg::*;
#(
  parameter int MAX_W  = 3840,
  parameter int MAX_H  = 2160,
  parameter int ICON_W = 64,
  parameter int ICON_H = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(MAX_W+1)-1:0]         cfg_width,
  input  logic [$clog2(MAX_H+1)-1:0]         cfg_height,
  input  logic                               cfg_icon_en,
  input  logic [$clog2(MAX_W/2+1)-1:0]       cfg_icon_dx,
  input  logic [$clog2(MAX_H+1)-1:0]         cfg_icon_dy,
  input  logic                               vid_stable,
  input  logic                               l1_valid,
  output logic                               l1_ready,
  input  logic [59:0]                        l1_data,
  input  logic                               l1_sof,
  input  logic                               l1_user,
  input  logic                               ic_valid,
  output logic                               ic_ready,
  input  logic [59:0]                        ic_data,
  input  logic                               ic_sof,
  input  logic                               ic_user,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [59:0]                        out_data,
  output logic                               out_sof,
  output logic                               out_eol
);
  localparam int XW = $clog2(MAX_W/PPC + 1);
  localparam int YW = $clog2(MAX_H + 1);
  localparam int IP = ICON_W / PPC;

  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // output register
  logic          ov_q, sof_q, eol_q;
  logic [DW-1:0] od_q, px;
  logic          adv;
  assign adv = rst_int_n && (!ov_q || out_ready);

  // raster
  logic [XW-1:0] x, w_eff, w_live;
  logic [YW-1:0] y;
  logic          sof, eol;
  assign w_live = XW'(cfg_width >> 1);

  mix_scan #(.XW(XW), .YW(YW)) u_scan (
    .clk(clk), .rst_n(rst_int_n), .adv(adv),
    .w_live(w_live), .h_live(cfg_height),
    .x(x), .y(y), .sof(sof), .eol(eol), .w_eff(w_eff)
  );

  // icon settings, sampled on the frame-start beat
  logic          ien_q, ien_d, ien_eff;
  logic [XW-1:0] dx_q, dx_d, dx_eff, xs, rx;
  logic [YW-1:0] dy_q, dy_d, dy_eff, ry;
  logic          icon_want;

  always_comb begin
    ien_eff   = sof ? cfg_icon_en : ien_q;
    dx_eff    = sof ? cfg_icon_dx : dx_q;
    dy_eff    = sof ? cfg_icon_dy : dy_q;
    xs        = w_eff - XW'(IP) - dx_eff;
    rx        = x - xs;
    ry        = y - dy_eff;
    icon_want = ien_eff && (x >= xs) && (rx < XW'(IP)) &&
                (y >= dy_eff) && (ry < YW'(ICON_H));
    ien_d     = ien_q;
    dx_d      = dx_q;
    dy_d      = dy_q;
    if (adv && sof) begin
      ien_d = cfg_icon_en;
      dx_d  = cfg_icon_dx;
      dy_d  = cfg_icon_dy;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ien_q <= 1'b0;
      dx_q  <= '0;
      dy_q  <= '0;
    end else begin
      ien_q <= ien_d;
      dx_q  <= dx_d;
      dy_q  <= dy_d;
    end
  end

  // layer ports
  logic          l1_hit, ic_hit;
  logic [DW-1:0] l1_pix, ic_pix, base;

  mix_layer_port #(.DW(DW)) u_l1 (
    .clk(clk), .rst_n(rst_int_n), .run(rst_int_n), .adv(adv),
    .frame_start(sof), .en(vid_stable), .want(1'b1),
    .s_valid(l1_valid), .s_sof(l1_sof), .s_user(l1_user), .s_data(l1_data),
    .s_ready(l1_ready), .hit(l1_hit), .pix(l1_pix)
  );

  mix_layer_port #(.DW(DW)) u_ic (
    .clk(clk), .rst_n(rst_int_n), .run(rst_int_n), .adv(adv),
    .frame_start(sof), .en(ien_eff), .want(icon_want),
    .s_valid(ic_valid), .s_sof(ic_sof), .s_user(ic_user), .s_data(ic_data),
    .s_ready(ic_ready), .hit(ic_hit), .pix(ic_pix)
  );

  assign base = l1_hit ? l1_pix : '0;

  mix_blend u_blend (.base(base), .ovl(ic_pix), .ovl_en(ic_hit), .px(px));

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ov_q  <= 1'b0;
      od_q  <= '0;
      sof_q <= 1'b0;
      eol_q <= 1'b0;
    end else if (adv) begin
      ov_q  <= 1'b1;
      od_q  <= px;
      sof_q <= sof;
      eol_q <= eol;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_sof   = sof_q;
  assign out_eol   = eol_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
    $stable(out_sof) && $stable(out_eol));

  // R3
  bg_continuous_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |=> out_valid);

  // R8
  user_accept_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    l1_valid && l1_user |-> l1_ready);

  // R6
  icon_window_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ic_valid && ic_ready && !ic_user |-> icon_want);
endmodule

// File: tb/sim_video_overlay_mixer.sv
`timescale 1ns/1ps
module sim_video_overlay_mixer;
  localparam int IW = 4, IH = 2, IP = IW / 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] cfg_width = 12'd8, cfg_height = 12'd4, cfg_icon_dy = '0;
  logic [10:0] cfg_icon_dx = '0;
  logic        cfg_icon_en = 1'b0, vid_stable = 1'b0, out_ready = 1'b1;
  logic        l1_valid, l1_ready, l1_sof, l1_user;
  logic        ic_valid, ic_ready, ic_sof, ic_user;
  logic [59:0] l1_data, ic_data, out_data;
  logic        out_valid, out_sof, out_eol;

  always #2.5 clk = ~clk;

  video_overlay_mixer #(.ICON_W(IW), .ICON_H(IH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_icon_en(cfg_icon_en), .cfg_icon_dx(cfg_icon_dx), .cfg_icon_dy(cfg_icon_dy),
    .vid_stable(vid_stable),
    .l1_valid(l1_valid), .l1_ready(l1_ready), .l1_data(l1_data), .l1_sof(l1_sof), .l1_user(l1_user),
    .ic_valid(ic_valid), .ic_ready(ic_ready), .ic_data(ic_data), .ic_sof(ic_sof), .ic_user(ic_user),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  int errors = 0, checks = 0, cyc = 0;

  function automatic int l1v(int y, int col, int p);
    return (y * 37 + col * 11 + p * 101 + 77) % 1024;
  endfunction
  function automatic int icv(int r, int col, int p);
    return (r * 53 + col * 29 + p * 7 + 500) % 1024;
  endfunction
  function automatic logic [59:0] l1_beat(int y, int x);
    logic [59:0] d;
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < 3; p++) d[h*30 + p*10 +: 10] = 10'(l1v(y, 2*x + h, p));
    return d;
  endfunction
  function automatic logic [59:0] ic_beat(int r, int c);
    logic [59:0] d;
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < 3; p++) d[h*30 + p*10 +: 10] = 10'(icv(r, 2*c + h, p));
    return d;
  endfunction
  function automatic logic [59:0] expect_px(bit vid, int y, int x, bit ic, int r, int c);
    logic [59:0] d;
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < 3; p++) begin
        int b, o;
        b = vid ? l1v(y, 2*x + h, p) : 0;
        o = icv(r, 2*c + h, p);
        d[h*30 + p*10 +: 10] = 10'(ic ? (b + o + 1) / 2 : b);
      end
    return d;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // ---- video source model ----
  int src_np = 4, src_h = 4, trunc = 0, stray_req = 0, stray_done = 0;
  int l1_idx = 0, l1_idle = 0;
  assign l1_valid = 1'b1;
  assign l1_user  = (l1_idle > 0);
  assign l1_sof   = (l1_idle == 0) && (stray_done >= stray_req) && (l1_idx == 0);
  assign l1_data  = (l1_idle > 0) ? '1 :
                    (stray_done < stray_req) ? 60'hABCDE_12345_0F0F0 :
                    l1_beat(l1_idx / src_np, l1_idx % src_np);

  always @(posedge clk) begin
    if (l1_idle > 0) l1_idle <= l1_idle - 1;
    else if (l1_valid && l1_ready) begin
      if (stray_done < stray_req) stray_done <= stray_done + 1;
      else if (l1_idx == src_np * src_h - 1) l1_idx <= 0;
      else if (trunc != 0 && l1_idx == trunc - 1) begin
        l1_idx  <= 0;
        l1_idle <= src_np * src_h - trunc;
      end else l1_idx <= l1_idx + 1;
    end
  end

  // ---- icon source model ----
  int ic_idx = 0;
  assign ic_valid = 1'b1;
  assign ic_user  = 1'b0;
  assign ic_sof   = (ic_idx == 0);
  assign ic_data  = ic_beat(ic_idx / IP, ic_idx % IP);
  always @(posedge clk)
    if (ic_valid && ic_ready) ic_idx <= (ic_idx == IP * IH - 1) ? 0 : ic_idx + 1;

  // ---- settings seen at each output load edge ----
  int cap_w, cap_h, cap_dx, cap_dy;
  bit cap_ien, cap_st, cap_l1h, cap_ich;
  always @(posedge clk)
    if (!out_valid || out_ready) begin
      cap_w <= int'(cfg_width); cap_h <= int'(cfg_height);
      cap_dx <= int'(cfg_icon_dx); cap_dy <= int'(cfg_icon_dy);
      cap_ien <= cfg_icon_en; cap_st <= vid_stable;
      cap_l1h <= l1_valid && l1_sof && !l1_user;
      cap_ich <= ic_valid && ic_sof && !ic_user;
    end

  // ---- output checker ----
  int k = 0, frames = 0, fr_np = 4, fr_h = 4, fr_dx = 0, fr_dy = 0;
  bit fr_vid = 0, fr_ic = 0, held_v = 0;
  logic [59:0] held;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
    if (!rst_n) begin
      if (cyc > 2) chk(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 0);
    end else begin
      if (held_v) chk(out_data == held && out_valid, "R9 stall hold", 64'(out_data), 64'(held));
      held_v = 0;
      if (l1_valid && l1_user) chk(l1_ready, "R8 user beat accepted", 64'(l1_ready), 1);
      if (l1_valid && stray_done < stray_req) chk(l1_ready, "R4 stray beat drained", 64'(l1_ready), 1);
      if (out_valid && !out_ready) begin held = out_data; held_v = 1; end
      if (out_valid && out_ready) begin
        int x, y, xs, r, c;
        bit vid, ic;
        logic [59:0] e;
        string tag;
        chk(out_sof == (k == 0), "R1 R2 sof position", 64'(out_sof), 64'(k == 0));
        if (k == 0) begin
          fr_np = cap_w / 2; fr_h = cap_h; fr_dx = cap_dx; fr_dy = cap_dy;
          fr_vid = cap_st && cap_l1h; fr_ic = cap_ien && cap_ich;
          frames++;
        end
        x = k % fr_np; y = k / fr_np;
        chk(out_eol == (x == fr_np - 1), "R2 eol position", 64'(out_eol), 64'(x == fr_np - 1));
        xs  = fr_np - IP - fr_dx;
        ic  = fr_ic && x >= xs && x < xs + IP && y >= fr_dy && y < fr_dy + IH;
        r   = y - fr_dy; c = x - xs;
        vid = fr_vid && (trunc == 0 || k < trunc);
        e   = expect_px(vid, y, x, ic, r, c);
        tag = ic ? "R6 R7 icon blend" : vid ? "R4 video shown" :
              (fr_vid ? "R5 stalled beat is background" : "R3 background black");
        chk(out_data == e, tag, 64'(out_data), 64'(e));
        k = (k + 1 == fr_np * fr_h) ? 0 : k + 1;
      end
    end
  end

  task automatic wait_frames(int n);
    int tgt;
    tgt = frames + n;
    while (frames < tgt) @(posedge clk);
    #1;
  endtask
  task automatic wait_mid();
    while (k != 5) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (6) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_frames(2);                                   // R3 black frames
    cfg_icon_en = 1'b1;                               // R6 over black
    wait_frames(2);
    stray_req = 3;                                    // R4 drain while unlocked
    wait_frames(2);
    vid_stable = 1'b1;                                // R4 video joins
    wait_frames(3);
    wait_mid(); cfg_icon_dx = 11'd1; cfg_icon_dy = 12'd2;   // R7 mid-frame move
    wait_frames(2);
    wait_mid(); cfg_icon_en = 1'b0;                   // R7 mid-frame disable
    wait_frames(2);
    wait_mid(); cfg_icon_en = 1'b1; cfg_icon_dx = '0; cfg_icon_dy = '0;
    wait_frames(1);
    wait_mid(); vid_stable = 1'b0;                    // R4 mid-frame drop
    wait_frames(2);
    trunc = 6;                                        // R5 R8 cut frames
    vid_stable = 1'b1;
    wait_frames(3);
    vid_stable = 1'b0;
    wait_frames(2);
    trunc = 0;
    cfg_width = 12'd12; cfg_height = 12'd3; src_np = 6; src_h = 3;   // R2 resize
    wait_frames(2);
    vid_stable = 1'b1;
    wait_frames(2);
    for (int i = 0; i < 90; i++) begin                // R9 backpressure
      out_ready = (i % 3 != 0) && (i % 7 != 2);
      @(posedge clk); #1;
    end
    out_ready = 1'b1;
    wait_frames(2);
    finish_run();
  end
endmodule